// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold offsets that a FIFO's programmable flags compare against: one for almost-empty and one for almost-full. While master reset is held, three strap inputs pick one of eight preset offsets, and the same straps fix how the offsets may be changed afterwards. Both registers take the preset value.

After reset, software changes the offsets through the method fixed at reset. In serial mode it shifts one bit per clock. In parallel mode it writes whole words from a data bus. In either mode it can read both offsets back over a parallel port, one after the other. The load strobe gates every access.

A partial reset rewinds the access sequence to its start. It does not touch the stored offsets or the method fixed at reset. The flag logic that uses the two outputs lives elsewhere.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrstN` is low on a clock edge, both offsets load the preset value (2^(i+3))-1 and `rdData` clears to zero. The index i is {`ldN`,`fsel[1]`,`fsel[0]`}, with `ldN` as the most significant bit.
- R2: The level of `ldN` during master reset fixes the programming method: low selects serial and high selects parallel. The method stays fixed until the next master reset.
- R3: In serial mode, each edge with `ldN` and `senN` both low writes `sdi` into one bit. The first 16 bits fill the almost-empty offset starting at bit 0. The next 16 bits fill the almost-full offset starting at bit 0. After the 32nd bit the position wraps to almost-empty bit 0.
- R4: An edge with `senN` high writes no serial bit and leaves both offsets unchanged.
- R5: In parallel mode, each edge with `ldN` and `wenN` both low stores `parData` into one offset. The writes alternate between the two offsets, almost-empty first.
- R6: In serial mode the parallel write strobe has no effect. In parallel mode the serial strobe has no effect.
- R7: In either mode, each edge with `ldN` and `renN` both low puts one offset on `rdData` from the next cycle on. The reads alternate, almost-empty first.
- R8: A partial reset (`prstN` low on an edge) keeps both offsets and the programming method. It returns the serial bit position, the parallel write order and the read order to their starting points.
- R9: With `ldN` high, `wenN`, `renN` and `senN` have no effect: the offsets and `rdData` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all loading and read-back |
| mrstN | input | 1 | Master reset, active low, sampled on the clock |
| prstN | input | 1 | Partial reset, active low, sampled on the clock |
| ldN | input | 1 | Load strobe, active low. During master reset it is the method strap |
| senN | input | 1 | Serial enable, active low |
| sdi | input | 1 | Serial data bit |
| fsel | input | 2 | Preset select straps, sampled during master reset |
| wenN | input | 1 | Parallel write enable, active low |
| renN | input | 1 | Parallel read enable, active low |
| parData | input | 16 | Parallel offset data |
| aeOffset | output | 16 | Almost-empty offset |
| afOffset | output | 16 | Almost-full offset |
| rdData | output | 16 | Read-back data |

## Verification
The assertions check on every cycle that:
- the serial bit position wraps after the last bit;
- a partial reset clears the sequence state and leaves both offsets unchanged;
- the offsets hold whenever no write strobe fires;
- an idle load strobe issues no access;
- each read returns the offset that was stored at the edge of the read.

Only the bench's scenarios can show that the straps pick the right preset value and method. The same holds for the serial bit order across the two registers and the wrap, for the alternating parallel write order, and for the lock-out of the method not selected.

// File: rtl/offld_pkg.sv
package offld_pkg;

  typedef struct packed {
    logic       loadDef;
    logic [2:0] defIdx;
    logic       serWr;
    logic       wrAe;
    logic       wrAf;
    logic       rdAe;
    logic       rdAf;
  } offld_strb_t;

  function automatic logic [31:0] presetOffset(input logic [2:0] idx);
    return (32'd1 << (idx + 32'd3)) - 32'd1;
  endfunction

endpackage

// File: rtl/offld_ctrl.sv
module offld_ctrl
  import offld_pkg::*;
#(
  parameter int OFS_W = 16,
  localparam int TOTAL_BITS = 2 * OFS_W,
  localparam int POS_W = $clog2(TOTAL_BITS)
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             ldN,
  input  logic             senN,
  input  logic [1:0]       fsel,
  input  logic             wenN,
  input  logic             renN,
  output offld_strb_t      strb,
  output logic [POS_W-1:0] bitPos
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(TOTAL_BITS - 1);

  logic serialMode;
  logic wrSelAf;
  logic rdSelAf;
  logic active;
  logic serGo;
  logic parGo;
  logic rdGo;

  always_comb begin
    active = mrstN && prstN;
    serGo  = active && !ldN && !senN && serialMode;
    parGo  = active && !ldN && !wenN && !serialMode;
    rdGo   = active && !ldN && !renN;

    strb.loadDef = !mrstN;
    strb.defIdx  = {ldN, fsel};
    strb.serWr   = serGo;
    strb.wrAe    = parGo && !wrSelAf;
    strb.wrAf    = parGo && wrSelAf;
    strb.rdAe    = rdGo && !rdSelAf;
    strb.rdAf    = rdGo && rdSelAf;
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      serialMode <= !ldN;
      bitPos     <= '0;
      wrSelAf    <= 1'b0;
      rdSelAf    <= 1'b0;
    end else if (!prstN) begin
      bitPos  <= '0;
      wrSelAf <= 1'b0;
      rdSelAf <= 1'b0;
    end else begin
      if (serGo) bitPos <= (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;
      if (parGo) wrSelAf <= !wrSelAf;
      if (rdGo)  rdSelAf <= !rdSelAf;
    end
  end

  // R3
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!mrstN)
    (strb.serWr && bitPos == LAST_POS) |=> (bitPos == '0));

  // R8
  prst_clear_chk: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> (bitPos == '0 && !wrSelAf && !rdSelAf));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!mrstN)
    ldN |-> !(strb.serWr || strb.wrAe || strb.wrAf || strb.rdAe || strb.rdAf));

  // R6
  lock_chk: assert property (@(posedge clk) disable iff (!mrstN)
    !(strb.serWr && (strb.wrAe || strb.wrAf)));

endmodule

// File: rtl/offld_dp.sv
module offld_dp
  import offld_pkg::*;
#(
  parameter int OFS_W = 16,
  localparam int TOTAL_BITS = 2 * OFS_W,
  localparam int POS_W = $clog2(TOTAL_BITS)
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  offld_strb_t      strb,
  input  logic [POS_W-1:0] bitPos,
  input  logic             sdi,
  input  logic [OFS_W-1:0] parData,
  output logic [OFS_W-1:0] aeOffset,
  output logic [OFS_W-1:0] afOffset,
  output logic [OFS_W-1:0] rdData
);

  logic [OFS_W-1:0] aeHit;
  logic [OFS_W-1:0] afHit;
  logic [OFS_W-1:0] presetVal;

  genvar gi;
  generate
    for (gi = 0; gi < OFS_W; gi++) begin : g_hit
      assign aeHit[gi] = strb.serWr && (bitPos == POS_W'(gi));
      assign afHit[gi] = strb.serWr && (bitPos == POS_W'(gi + OFS_W));
    end
  endgenerate

  always_comb begin
    logic [31:0] full;
    full      = presetOffset(strb.defIdx);
    presetVal = full[OFS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.loadDef) begin
      aeOffset <= presetVal;
      afOffset <= presetVal;
      rdData   <= '0;
    end else begin
      if (strb.wrAe) aeOffset <= parData;
      else aeOffset <= (aeOffset & ~aeHit) | (aeHit & {OFS_W{sdi}});
      if (strb.wrAf) afOffset <= parData;
      else afOffset <= (afOffset & ~afHit) | (afHit & {OFS_W{sdi}});
      if (strb.rdAe)      rdData <= aeOffset;
      else if (strb.rdAf) rdData <= afOffset;
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!mrstN)
    (!strb.serWr && !strb.wrAe && !strb.wrAf) |=>
      ($stable(aeOffset) && $stable(afOffset)));

  // R7
  rd_ae_chk: assert property (@(posedge clk) disable iff (!mrstN)
    strb.rdAe |=> (rdData == $past(aeOffset)));

  // R7
  rd_af_chk: assert property (@(posedge clk) disable iff (!mrstN)
    strb.rdAf |=> (rdData == $past(afOffset)));

  // R8
  prst_keep_chk: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> ($stable(aeOffset) && $stable(afOffset)));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import offld_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             ldN,
  input  logic             senN,
  input  logic             sdi,
  input  logic [1:0]       fsel,
  input  logic             wenN,
  input  logic             renN,
  input  logic [OFS_W-1:0] parData,
  output logic [OFS_W-1:0] aeOffset,
  output logic [OFS_W-1:0] afOffset,
  output logic [OFS_W-1:0] rdData
);

  localparam int POS_W = $clog2(2 * OFS_W);

  offld_strb_t      strb;
  logic [POS_W-1:0] bitPos;

  offld_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .ldN(ldN), .senN(senN),
    .fsel(fsel), .wenN(wenN), .renN(renN), .strb(strb), .bitPos(bitPos)
  );

  offld_dp #(.OFS_W(OFS_W)) u_dp (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .strb(strb), .bitPos(bitPos),
    .sdi(sdi), .parData(parData), .aeOffset(aeOffset), .afOffset(afOffset),
    .rdData(rdData)
  );

endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  logic clk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, ldN = 1'b1, senN = 1'b1, sdi = 1'b0;
  logic wenN = 1'b1, renN = 1'b1;
  logic [1:0] fsel = 2'd0;
  logic [15:0] parData = '0;
  logic [15:0] aeOffset, afOffset, rdData;

  int checks = 0, failures = 0;
  logic [15:0] mAe, mAf, lastRd;
  logic mSerial, mWrAf, mRdAf;
  int mPos;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  flag_offset_loader dut (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .ldN(ldN), .senN(senN), .sdi(sdi),
    .fsel(fsel), .wenN(wenN), .renN(renN), .parData(parData),
    .aeOffset(aeOffset), .afOffset(afOffset), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    check(req, aeOffset, mAe);
    check(req, afOffset, mAf);
  endtask

  task automatic doMrst(input logic ldS, input logic [1:0] fs);
    mrstN = 1'b0; ldN = ldS; fsel = fs;
    repeat (3) @(negedge clk);
    mrstN = 1'b1; ldN = 1'b1;
    mAe = 16'((32'd1 << ({29'd0, ldS, fs} + 32'd3)) - 32'd1);
    mAf = mAe; mSerial = !ldS; mPos = 0; mWrAf = 1'b0; mRdAf = 1'b0;
    lastRd = '0;
  endtask

  task automatic doPrst();
    prstN = 1'b0;
    @(negedge clk);
    prstN = 1'b1;
    mPos = 0; mWrAf = 1'b0; mRdAf = 1'b0;
  endtask

  task automatic parWrite(input logic [15:0] v);
    ldN = 1'b0; wenN = 1'b0; parData = v;
    @(negedge clk);
    ldN = 1'b1; wenN = 1'b1;
    if (!mSerial) begin
      if (mWrAf) mAf = v; else mAe = v;
      mWrAf = !mWrAf;
    end
  endtask

  task automatic serBit(input logic b);
    logic [31:0] both;
    ldN = 1'b0; senN = 1'b0; sdi = b;
    @(negedge clk);
    ldN = 1'b1; senN = 1'b1;
    if (mSerial) begin
      both = {mAf, mAe};
      both[mPos] = b;
      {mAf, mAe} = both;
      mPos = (mPos == 31) ? 0 : mPos + 1;
    end
  endtask

  task automatic serWord(input logic [15:0] v);
    for (int i = 0; i < 16; i++) serBit(v[i]);
  endtask

  task automatic doRead();
    lastRd = mRdAf ? mAf : mAe;
    expQ.push_back(lastRd);
    mRdAf = !mRdAf;
    ldN = 1'b0; renN = 1'b0;
    @(negedge clk);
    ldN = 1'b1; renN = 1'b1;
  endtask

  // scoreboard monitor for read-back (R7)
  initial begin
    logic fire;
    forever begin
      @(posedge clk);
      fire = mrstN && prstN && !ldN && !renN;
      @(negedge clk);
      if (fire) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 actual=%h expected=<none>", rdData);
        end else begin
          check("R7", rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 R2: parallel mode, index 6 -> 511
    doMrst(1'b1, 2'd2);
    checkRegs("R1");
    check("R1", rdData, 16'h0000);

    // R5: alternating parallel writes
    parWrite(16'h1234);
    check("R5", aeOffset, 16'h1234);
    check("R5", afOffset, mAf);
    parWrite(16'hBEEF);
    checkRegs("R5");

    // R6: serial strobes ignored in parallel mode
    for (int i = 0; i < 3; i++) serBit(1'b1);
    checkRegs("R6");

    // R7: read order ae, af, ae
    doRead(); doRead(); doRead();
    @(negedge clk);

    // R9: strobes ignored with load high
    wenN = 1'b0; renN = 1'b0; senN = 1'b0; parData = 16'hDEAD;
    repeat (2) @(negedge clk);
    wenN = 1'b1; renN = 1'b1; senN = 1'b1;
    checkRegs("R9");
    check("R9", rdData, lastRd);

    // R8: partial reset rewinds order, keeps values
    parWrite(16'h0055);
    doPrst();
    checkRegs("R8");
    parWrite(16'h7777);
    check("R8", aeOffset, 16'h7777);
    check("R8", afOffset, 16'hBEEF);
    doRead();
    @(negedge clk);

    // R1 R2: serial mode, index 1 -> 15
    doMrst(1'b0, 2'd1);
    checkRegs("R1");
    check("R2", aeOffset, 16'd15);

    // R3 R4: serial fill with a pause
    serWord(16'hA5C3);
    ldN = 1'b0; senN = 1'b1; sdi = 1'b1;
    @(negedge clk);
    ldN = 1'b1;
    checkRegs("R4");
    check("R3", aeOffset, 16'hA5C3);
    serWord(16'h0F1E);
    check("R3", afOffset, 16'h0F1E);
    checkRegs("R3");

    // R6: parallel write ignored in serial mode
    parWrite(16'h4444);
    checkRegs("R6");

    // R3: wrap into almost-empty bit 0
    for (int i = 0; i < 4; i++) serBit(1'b0);
    check("R3", aeOffset, 16'hA5C0);
    checkRegs("R3");

    // R7 in serial mode
    doRead(); doRead();
    @(negedge clk);

    // R8: serial mode kept, position rewound
    serBit(1'b1); serBit(1'b1);
    doPrst();
    checkRegs("R8");
    serBit(1'b1);
    check("R8", aeOffset, mAe);
    check("R8", aeOffset[0], 1'b1);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule